// File: doc/BRIEF.md
# Bitmap Centralized Lock Controller

This block is the home-node engine for a small table of hardware locks. Every lock carries a held/free flag, the identity of its current owner and a full-map waiter vector with one bit per node. The engine consumes two kinds of message, an acquire request and a release, each naming a lock index and a node id. It emits grant messages that name a lock index and the node that now owns the lock.

An acquire aimed at a free lock is granted at once. An acquire aimed at a held lock only marks the requester in the waiter vector and produces no reply. A release by the owner either frees the lock, when nobody waits, or passes ownership directly to one waiter. That waiter is picked pseudo-randomly, by a priority search over the waiter bits that starts at a point taken from a free-running LFSR. No first-come ordering between waiters is promised, so a waiter can in principle starve.

Messages enter through a valid/ready handshake, one per cycle at most. Grants leave through a single output register with a valid/ready handshake, and a stalled grant holds off new messages. Messages that break the protocol set a sticky error flag and change nothing else.

Top module: `lockctl_central`

## Requirements
- R1: After reset every lock is free with an empty waiter vector, no grant is pending, the error flag is low and the message input is ready.
- R2: An acquire (kind bit 0) to a free lock makes the lock held by the requester, and in the cycle after acceptance grant_valid_o is high with grant_lock_o and grant_node_o naming that lock and requester.
- R3: An acquire to a lock held by another node, from a node not already waiting, records the requester as a waiter and produces no grant.
- R4: A release (kind bit 1) by the owner of a lock whose waiter vector is empty makes the lock free and produces no grant; a later acquire to it is granted at once.
- R5: A release by the owner of a lock with waiters produces, in the cycle after acceptance, a grant for that lock to a node that was waiting; that node becomes the owner and leaves the waiter vector, and the other waiters stay recorded.
- R6: The choice among waiters is not fixed: with the same two waiters present over repeated handoffs, each of them is chosen at least once.
- R7: A message is accepted only on a cycle with msg_valid_i and msg_ready_o both high; msg_ready_o is low exactly when a grant is pending and grant_ready_i is low, and a pending grant keeps its lock and node stable until taken.
- R8: A release from a node that is not the owner or to a free lock, and an acquire from the owner or from a node already waiting, set err_o, which then stays high until reset; such a message changes no lock state and produces no grant.
- R9: Locks are independent: messages to one lock never alter the ownership or waiters of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Incoming message valid |
| msg_ready_o | output | 1 | Engine can take a message this cycle |
| msg_kind_i | input | 1 | 0 = acquire request, 1 = release |
| msg_lock_i | input | LOCK_W | Lock index of the message |
| msg_node_i | input | NODE_W | Sending node id |
| grant_valid_o | output | 1 | Grant message pending |
| grant_ready_i | input | 1 | Downstream takes the grant |
| grant_lock_o | output | LOCK_W | Lock index of the grant |
| grant_node_o | output | NODE_W | Destination node of the grant |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
The hardest condition to reach is a handoff among several waiters whose winner cannot be predicted, especially when the grant output is stalled and new messages queue behind it. The bench therefore treats the winner as a set-membership check: its model remembers the waiter vector at the moment of the release, accepts any member as the new owner and then removes exactly that node. A directed loop keeps rebuilding the same two-waiter lock with random idle gaps, so the free-running pick start lands on different sides of both waiters. A long random phase with random grant backpressure mixes releases, new waiters and back-to-back traffic to the same lock.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;

  typedef enum logic {
    MSG_ACQ = 1'b0,
    MSG_REL = 1'b1
  } msg_kind_e;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_TAKE    = 3'd1,
    ACT_ENQUEUE = 3'd2,
    ACT_FREE    = 3'd3,
    ACT_HANDOFF = 3'd4,
    ACT_ERROR   = 3'd5
  } lock_act_e;

  // Decide what one accepted message does to the addressed lock.
  function automatic lock_act_e classify_msg(
    input msg_kind_e kind,
    input logic      held,
    input logic      from_owner,
    input logic      already_waiting,
    input logic      has_waiters
  );
    lock_act_e act;
    if (kind == MSG_ACQ) begin
      if (!held)                              act = ACT_TAKE;
      else if (from_owner || already_waiting) act = ACT_ERROR;
      else                                    act = ACT_ENQUEUE;
    end else begin
      if (!held || !from_owner)               act = ACT_ERROR;
      else if (has_waiters)                   act = ACT_HANDOFF;
      else                                    act = ACT_FREE;
    end
    return act;
  endfunction

endpackage

// File: rtl/lockctl_lfsr.sv
module lockctl_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rand_o
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  // Galois form: shift right, fold the taps in when the outgoing bit is set.
  always_comb begin
    state_d = {1'b0, state_q[WIDTH-1:1]};
    if (state_q[0]) state_d = state_d ^ TAPS[WIDTH-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED[WIDTH-1:0];
    else         state_q <= state_d;
  end

  assign rand_o = state_q[OUT_W-1:0];

  assert_lfsr_alive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

endmodule

// File: rtl/lockctl_pick.sv
module lockctl_pick #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_vec_i,
  input  logic [IW-1:0] start_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  // First set bit at or after the start point, wrapping round the vector.
  function automatic logic [IW-1:0] first_from(
    input logic [N-1:0]  v,
    input logic [IW-1:0] s
  );
    logic [IW-1:0] res;
    logic          hit;
    int            j;
    res = '0;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      j = (int'(s) + i) % N;
      if (!hit && v[j]) begin
        hit = 1'b1;
        res = j[IW-1:0];
      end
    end
    return res;
  endfunction

  assign found_o = |req_vec_i;
  assign idx_o   = first_from(req_vec_i, start_i);

endmodule

// File: rtl/lockctl_table.sv
module lockctl_table
  import lockctl_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int NUM_NODES = 64,
  localparam int LOCK_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int NODE_W   = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LOCK_W-1:0]    rd_lock_i,
  output logic                 rd_held_o,
  output logic [NODE_W-1:0]    rd_owner_o,
  output logic [NUM_NODES-1:0] rd_wait_o,
  input  logic                 upd_en_i,
  input  lock_act_e            upd_act_i,
  input  logic [NODE_W-1:0]    upd_node_i,
  input  logic [NODE_W-1:0]    upd_pick_i
);

  logic                 held_q  [NUM_LOCKS];
  logic [NODE_W-1:0]    owner_q [NUM_LOCKS];
  logic [NUM_NODES-1:0] wait_q  [NUM_LOCKS];

  assign rd_held_o  = held_q[rd_lock_i];
  assign rd_owner_o = owner_q[rd_lock_i];
  assign rd_wait_o  = wait_q[rd_lock_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_LOCKS; k++) begin
        held_q[k]  <= 1'b0;
        owner_q[k] <= '0;
        wait_q[k]  <= '0;
      end
    end else if (upd_en_i) begin
      case (upd_act_i)
        ACT_TAKE: begin
          held_q[rd_lock_i]  <= 1'b1;
          owner_q[rd_lock_i] <= upd_node_i;
        end
        ACT_ENQUEUE: wait_q[rd_lock_i][upd_node_i] <= 1'b1;
        ACT_FREE:    held_q[rd_lock_i] <= 1'b0;
        ACT_HANDOFF: begin
          wait_q[rd_lock_i][upd_pick_i] <= 1'b0;
          owner_q[rd_lock_i]            <= upd_pick_i;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock_chk
    assert_free_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !held_q[g] |-> (wait_q[g] == '0));
    assert_untouched_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(upd_en_i && rd_lock_i == g) |=> ($stable(held_q[g]) && $stable(wait_q[g])));
  end

endmodule

// File: rtl/lockctl_central.sv
module lockctl_central
  import lockctl_pkg::*;
#(
  parameter int NUM_LOCKS = 8,
  parameter int NUM_NODES = 64,
  parameter int LFSR_W    = 16,
  localparam int LOCK_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
  localparam int NODE_W   = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  output logic              msg_ready_o,
  input  logic              msg_kind_i,
  input  logic [LOCK_W-1:0] msg_lock_i,
  input  logic [NODE_W-1:0] msg_node_i,
  output logic              grant_valid_o,
  input  logic              grant_ready_i,
  output logic [LOCK_W-1:0] grant_lock_o,
  output logic [NODE_W-1:0] grant_node_o,
  output logic              err_o
);

  logic                 rd_held;
  logic [NODE_W-1:0]    rd_owner;
  logic [NUM_NODES-1:0] rd_wait;
  logic [NODE_W-1:0]    pick_start;
  logic [NODE_W-1:0]    pick_idx;
  logic                 pick_found;
  lock_act_e            act;
  logic                 fire;

  // Named internal events.
  logic ev_take, ev_enqueue, ev_free, ev_handoff, ev_error;

  logic              gnt_valid_q;
  logic [LOCK_W-1:0] gnt_lock_q;
  logic [NODE_W-1:0] gnt_node_q;
  logic              err_q;

  lockctl_table #(
    .NUM_LOCKS (NUM_LOCKS),
    .NUM_NODES (NUM_NODES)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_lock_i  (msg_lock_i),
    .rd_held_o  (rd_held),
    .rd_owner_o (rd_owner),
    .rd_wait_o  (rd_wait),
    .upd_en_i   (fire),
    .upd_act_i  (act),
    .upd_node_i (msg_node_i),
    .upd_pick_i (pick_idx)
  );

  lockctl_lfsr #(
    .WIDTH (LFSR_W),
    .OUT_W (NODE_W)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rand_o (pick_start)
  );

  lockctl_pick #(
    .N  (NUM_NODES),
    .IW (NODE_W)
  ) u_pick (
    .req_vec_i (rd_wait),
    .start_i   (pick_start),
    .found_o   (pick_found),
    .idx_o     (pick_idx)
  );

  assign msg_ready_o = !gnt_valid_q || grant_ready_i;
  assign fire        = msg_valid_i && msg_ready_o;

  assign act = classify_msg(msg_kind_e'(msg_kind_i),
                            rd_held,
                            rd_held && (rd_owner == msg_node_i),
                            rd_wait[msg_node_i],
                            pick_found);

  assign ev_take    = fire && (act == ACT_TAKE);
  assign ev_enqueue = fire && (act == ACT_ENQUEUE);
  assign ev_free    = fire && (act == ACT_FREE);
  assign ev_handoff = fire && (act == ACT_HANDOFF);
  assign ev_error   = fire && (act == ACT_ERROR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_valid_q <= 1'b0;
      gnt_lock_q  <= '0;
      gnt_node_q  <= '0;
    end else if (ev_take) begin
      gnt_valid_q <= 1'b1;
      gnt_lock_q  <= msg_lock_i;
      gnt_node_q  <= msg_node_i;
    end else if (ev_handoff) begin
      gnt_valid_q <= 1'b1;
      gnt_lock_q  <= msg_lock_i;
      gnt_node_q  <= pick_idx;
    end else if (grant_ready_i) begin
      gnt_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (ev_error) err_q <= 1'b1;
  end

  assign grant_valid_o = gnt_valid_q;
  assign grant_lock_o  = gnt_lock_q;
  assign grant_node_o  = gnt_node_q;
  assign err_o         = err_q;

  assert_take_grants_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_take |=> (grant_valid_o && grant_node_o == $past(msg_node_i)
                 && grant_lock_o == $past(msg_lock_i)));

  assert_pick_waiter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_handoff |-> rd_wait[pick_idx]);

  assert_handoff_grants_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_handoff |=> (grant_valid_o && grant_lock_o == $past(msg_lock_i)));

  assert_quiet_enqueue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_enqueue || ev_free || ev_error) |=> !grant_valid_o || $stable(grant_node_o));

  assert_grant_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !grant_ready_i) |=>
      (grant_valid_o && $stable(grant_lock_o) && $stable(grant_node_o)));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

endmodule

// File: tb/lockctl_central_tb_top.sv
`timescale 1ns/1ps
module lockctl_central_tb_top;

  localparam int NL = 8;
  localparam int NN = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       msg_valid = 1'b0;
  logic       msg_ready;
  logic       msg_kind = 1'b0;
  logic [2:0] msg_lock = '0;
  logic [5:0] msg_node = '0;
  logic       grant_valid;
  logic       grant_ready = 1'b1;
  logic [2:0] grant_lock;
  logic [5:0] grant_node;
  logic       err;

  always #2.5 clk = ~clk;

  lockctl_central #(.NUM_LOCKS(NL), .NUM_NODES(NN)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .msg_valid_i   (msg_valid),
    .msg_ready_o   (msg_ready),
    .msg_kind_i    (msg_kind),
    .msg_lock_i    (msg_lock),
    .msg_node_i    (msg_node),
    .grant_valid_o (grant_valid),
    .grant_ready_i (grant_ready),
    .grant_lock_o  (grant_lock),
    .grant_node_o  (grant_node),
    .err_o         (err)
  );

  int checks = 0;
  int failures = 0;
  string phase = "init";

  // Behavioural model
  bit          m_held  [NL];
  int          m_owner [NL];
  bit [NN-1:0] m_wait  [NL];
  bit          e_gv;
  int          e_glock, e_gnode;
  bit          e_err;
  string       e_tag = "R1";
  bit          pend;
  int          pend_lock;
  bit [NN-1:0] pend_set;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s phase=%s actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NL; k++) begin
      m_held[k] = 0; m_owner[k] = 0; m_wait[k] = '0;
    end
    e_gv = 0; e_glock = 0; e_gnode = 0; e_err = 0; pend = 0; e_tag = "R1";
  endtask

  // Compare outputs at a negedge against the model.
  task automatic check_outputs();
    if (pend) begin
      chk(grant_valid == 1'b1, "R5", grant_valid, 1);
      chk(int'(grant_lock) == pend_lock, "R5", grant_lock, pend_lock);
      chk(pend_set[grant_node] == 1'b1, "R5", grant_node, longint'(pend_set));
      m_owner[pend_lock] = int'(grant_node);
      m_wait[pend_lock][grant_node] = 1'b0;
      e_gnode = int'(grant_node);
      pend = 0;
    end
    chk(grant_valid == e_gv, e_tag, grant_valid, e_gv);
    if (e_gv) begin
      chk(int'(grant_lock) == e_glock, e_tag, grant_lock, e_glock);
      chk(int'(grant_node) == e_gnode, e_tag, grant_node, e_gnode);
    end
    chk(err == e_err, "R8", err, e_err);
  endtask

  task automatic model_update(input bit fire, input bit gr, input bit k, input int l, input int n);
    if (e_gv && gr) begin e_gv = 0; e_tag = "R7"; end
    if (!fire) return;
    if (k == 1'b0) begin
      if (!m_held[l]) begin
        m_held[l] = 1; m_owner[l] = n;
        e_gv = 1; e_glock = l; e_gnode = n; e_tag = "R2";
      end else if (m_owner[l] == n || m_wait[l][n]) begin
        e_err = 1; e_tag = "R8";
      end else begin
        m_wait[l][n] = 1'b1; e_tag = "R3";
      end
    end else begin
      if (!m_held[l] || m_owner[l] != n) begin
        e_err = 1; e_tag = "R8";
      end else if (m_wait[l] == '0) begin
        m_held[l] = 0; e_tag = "R4";
      end else begin
        e_gv = 1; e_glock = l; pend = 1; pend_lock = l; pend_set = m_wait[l]; e_tag = "R5";
      end
    end
  endtask

  // One cycle: caller is at a negedge.
  task automatic step(input bit v, input bit k, input int l, input int n, input bit gr);
    bit fire;
    check_outputs();
    msg_valid = v; msg_kind = k; msg_lock = l[2:0]; msg_node = n[5:0]; grant_ready = gr;
    #1;
    chk(msg_ready == (!e_gv || gr), "R7", msg_ready, (!e_gv || gr));
    fire = v && msg_ready;
    model_update(fire, gr, k, l, n);
    @(negedge clk);
  endtask

  task automatic acq(input int l, input int n); step(1, 1'b0, l, n, 1); endtask
  task automatic rel(input int l, input int n); step(1, 1'b1, l, n, 1); endtask
  task automatic idle(input int c);
    for (int i = 0; i < c; i++) step(0, 1'b0, 0, 0, 1);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; msg_valid = 1'b0; grant_ready = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    rst_ni = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk(grant_valid == 1'b0, "R1", grant_valid, 0);
    chk(err == 1'b0, "R1", err, 0);
    chk(msg_ready == 1'b1, "R1", msg_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog phase=%s actual=%0d expected=%0d", phase, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit saw5, saw40;
    do_reset();

    phase = "R2";
    acq(0, 7); idle(1);
    phase = "R3";
    acq(0, 12); acq(0, 33); idle(2);

    phase = "R5";
    rel(0, 7);
    // stall the grant; a message offered meanwhile must not be taken (R7)
    step(0, 1'b0, 0, 0, 0);
    phase = "R7";
    step(1, 1'b0, 2, 9, 0);
    step(1, 1'b0, 2, 9, 0);
    step(0, 1'b0, 0, 0, 1);
    idle(1);

    phase = "R4";
    rel(0, m_owner[0]); idle(1);
    rel(0, m_owner[0]); idle(1);
    acq(0, 2); idle(1);

    phase = "R9";
    acq(1, 3); acq(5, 4); acq(1, 4); acq(5, 3); idle(1);
    rel(5, 4); idle(1);
    rel(1, 3); idle(1);
    chk(m_owner[1] == 4 && m_owner[5] == 3, "R9", m_owner[1], 4);
    rel(1, 4); rel(5, 3); idle(1);

    phase = "R6";
    saw5 = 0; saw40 = 0;
    acq(3, 1); idle(1);
    for (int t = 0; t < 24; t++) begin
      int w;
      acq(3, 5); acq(3, 40);
      idle($urandom_range(0, 5));
      rel(3, m_owner[3]); idle(1);
      w = m_owner[3];
      if (w == 5) saw5 = 1;
      if (w == 40) saw40 = 1;
      rel(3, w); idle(1);
      rel(3, m_owner[3]); idle(1);
      rel(3, m_owner[3]); idle(1);
      acq(3, 1); idle(1);
    end
    chk(saw5 && saw40, "R6", {saw5, saw40}, 3);

    phase = "random";
    for (int t = 0; t < 4000; t++) begin
      int l, n;
      bit gr;
      l = $urandom_range(0, NL - 1);
      gr = ($urandom_range(0, 9) < 7);
      if (m_held[l] && $urandom_range(0, 2) == 0 && !pend)
        step(1, 1'b1, l, m_owner[l], gr);
      else begin
        n = $urandom_range(0, NN - 1);
        step($urandom_range(0, 4) != 0, 1'b0, l, n, gr);
      end
    end
    idle(2);

    // Each error kind from a clean reset; state must be unchanged afterwards.
    phase = "R8-dupwait";
    do_reset(); acq(4, 1); acq(4, 2); acq(4, 2); idle(1);
    rel(4, 1); idle(1);
    chk(int'(grant_node) == 2, "R8", grant_node, 2);
    phase = "R8-notowner";
    do_reset(); acq(4, 1); rel(4, 9); idle(1); acq(4, 9); idle(1);
    chk(grant_valid == 1'b0, "R8", grant_valid, 0);
    phase = "R8-ownerreq";
    do_reset(); acq(6, 8); acq(6, 8); idle(1); rel(6, 8); acq(6, 11); idle(1);
    phase = "R8-freerel";
    do_reset(); rel(2, 5); idle(1); acq(2, 5); idle(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule